// File: doc/BRIEF.md
# Loopback UART Register Block

This block presents the familiar eight-register 16550 programming model to a host bus, but it has no serial line behind it. Every byte the host writes to the data register is stored in an internal circular queue, and every read of the data register takes the oldest byte out of that same queue, so the port always talks to itself. The host sees line status, modem status and interrupt identification that are derived from how full the queue is and whether a byte has been lost. Baud generation, the shift register, parity and the character timeout are not modelled.

The host side uses separate read and write address ports, a read strobe and a write strobe. Read data is combinational and valid while the read strobe is high. Side effects such as dequeuing, latching and clearing happen on the rising clock edge that ends the access. Interrupt events are reported as a one-cycle pulse on `irq_pulse`, which is registered and therefore appears in the cycle after the access that caused it. The register offsets follow the standard layout: 0 data/divisor low, 1 interrupt enable/divisor high, 2 identification (read) and FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `lbu_regs_top`

## Requirements
- R1: After reset, identification reads 0xC1, line status reads 0x60, modem status reads 0xB3, and interrupt enable, line control, modem control and scratch read 0x00. `irq_pulse` is low.
- R2: Bytes written to offset 0 are read back from offset 0 in the order they were written. The queue holds 16 bytes. Line status bit 0 is 1 while the queue holds data. Bits 5 and 6 are both 1 while the queue is empty.
- R3: A data write to a full queue is dropped and sets the overrun flag, which is line status bit 1. If interrupt enable bit 2 is set, the dropped write also pulses the interrupt. The next accepted data write clears the overrun flag.
- R4: A data read from an empty queue returns 0x00 and leaves the queue unchanged.
- R5: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. In this state no byte is queued or dequeued and interrupt enable is left unchanged. Any line control write with bit 7 set clears both divisor bytes to zero.
- R6: FIFO control bit 0 = 0 limits the queue to 1 byte and sets the trigger level to 1. With bit 0 = 1, bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. Setting bit 1 or bit 2 empties the queue.
- R7: If interrupt enable bit 0 is set, an accepted data write pulses the interrupt when the resulting count equals the trigger level exactly. Counts above the level do not pulse.
- R8: Identification reads the highest-priority pending cause, with bits 7:6 always 1. The causes, highest first, are: overrun with enable bit 2 (0xC6), count at or above the trigger level with enable bit 0 (0xC4), empty queue with enable bit 1 (0xC2), and modem control bit 0 or 1 set with enable bit 3 (0xC0). With no cause pending it reads 0xC1.
- R9: Modem status always has bits 7, 5 and 1 set. It also sets bits 4 and 0 unless modem control bit 5 is set and the queue is full.
- R10: If enable bit 1 was already set, a data read that removes the last byte pulses the interrupt. An interrupt enable write with bit 1 set while the queue is empty also pulses. Interrupt enable reads return only the low four bits.
- R11: A data write and a data read in the same cycle dequeue the oldest byte and queue the new one. The write is accepted if the queue has room once the read's byte has been removed, so a full queue accepts it.
- R12: `irq_pulse` is high for exactly one cycle, the cycle after an access that raised an event, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| irq_pulse | output | 1 | One-cycle interrupt event |

## Verification
A data write and a data read can happen in the same cycle. Both then act on the one shared queue: the dequeue, the enqueue, the overrun decision and the interrupt events all have to agree. The bench fills the queue to 16 bytes and forces an overrun. It then issues a simultaneous write and read. It expects the oldest byte to be returned, the new byte to be accepted, overrun to clear and no interrupt pulse. Draining the queue afterwards must show the new byte last.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    typedef enum logic [2:0] {
        REG_DATA      = 3'd0,
        REG_IEN       = 3'd1,
        REG_IDENT     = 3'd2,
        REG_LINECTL   = 3'd3,
        REG_MODEMCTL  = 3'd4,
        REG_LINESTAT  = 3'd5,
        REG_MODEMSTAT = 3'd6,
        REG_SCRATCH   = 3'd7
    } reg_addr_e;

    localparam int IEN_RXDATA   = 0;
    localparam int IEN_TXEMPTY  = 1;
    localparam int IEN_LINESTAT = 2;
    localparam int IEN_MODEM    = 3;

    localparam int LCR_DIVACC   = 7;

    localparam int MCR_DTR      = 0;
    localparam int MCR_RTS      = 1;
    localparam int MCR_AUTOFLOW = 5;

    localparam int FCR_ENABLE   = 0;
    localparam int FCR_CLR_RX   = 1;
    localparam int FCR_CLR_TX   = 2;

    typedef struct packed {
        logic [3:0] ien;
        logic [7:0] linectl;
        logic [7:0] modemctl;
        logic [7:0] scratch;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic       fifo_on;
        logic [1:0] trig_sel;
    } cfg_t;

    function automatic logic [4:0] trig_level(input logic fifo_on, input logic [1:0] sel);
        logic [4:0] lvl;
        if (!fifo_on) begin
            lvl = 5'd1;
        end else begin
            case (sel)
                2'b00:   lvl = 5'd1;
                2'b01:   lvl = 5'd4;
                2'b10:   lvl = 5'd8;
                default: lvl = 5'd14;
            endcase
        end
        return lvl;
    endfunction

    function automatic logic [7:0] ident_code(input logic ls, input logic rd,
                                              input logic te, input logic ms);
        logic [7:0] code;
        if (ls)      code = 8'hC6;
        else if (rd) code = 8'hC4;
        else if (te) code = 8'hC2;
        else if (ms) code = 8'hC0;
        else         code = 8'hC1;
        return code;
    endfunction

endpackage

// File: rtl/lbu_loop_fifo.sv
module lbu_loop_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clr,
    input  logic [CW-1:0]    limit,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    count_nxt,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overrun
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    after_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty     = (count == '0);
    assign pop_ok    = pop && !clr && !empty;
    assign after_pop = count - CW'(pop_ok);
    assign push_ok   = push && !clr && (after_pop < limit);
    assign head_data = empty ? '0 : mem[rd_ptr];

    always_comb begin
        if (clr) count_nxt = '0;
        else     count_nxt = after_pop + CW'(push_ok);
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            count <= count_nxt;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= step(wr_ptr);
                if (pop_ok)  rd_ptr <= step(rd_ptr);
            end
            if (push_ok)                overrun <= 1'b0;
            else if (push && !clr)      overrun <= 1'b1;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    assert_reject_sets_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        (push && !push_ok && !clr) |=> overrun);

    assert_empty_read_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !clr) |=> (count == '0) && $stable(rd_ptr));

endmodule

// File: rtl/lbu_ctrl_regs.sv
module lbu_ctrl_regs
    import lbu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output cfg_t       cfg,
    output logic       push_req,
    output logic       clr_req,
    output logic       ien_txempty_wr
);

    reg_addr_e wsel;
    logic      divacc;

    assign wsel   = reg_addr_e'(wr_addr);
    assign divacc = cfg.linectl[LCR_DIVACC];

    assign push_req       = wr_en && (wsel == REG_DATA) && !divacc;
    assign clr_req        = wr_en && (wsel == REG_IDENT) &&
                            (wr_data[FCR_CLR_RX] || wr_data[FCR_CLR_TX]);
    assign ien_txempty_wr = wr_en && (wsel == REG_IEN) && !divacc &&
                            wr_data[IEN_TXEMPTY];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg          <= '0;
            cfg.fifo_on  <= 1'b1;
        end else if (wr_en) begin
            case (wsel)
                REG_DATA: begin
                    if (divacc) cfg.div_lo <= wr_data;
                end
                REG_IEN: begin
                    if (divacc) cfg.div_hi <= wr_data;
                    else        cfg.ien    <= wr_data[3:0];
                end
                REG_IDENT: begin
                    cfg.fifo_on  <= wr_data[FCR_ENABLE];
                    cfg.trig_sel <= wr_data[7:6];
                end
                REG_LINECTL: begin
                    cfg.linectl <= wr_data;
                    if (wr_data[LCR_DIVACC]) begin
                        cfg.div_lo <= '0;
                        cfg.div_hi <= '0;
                    end
                end
                REG_MODEMCTL: cfg.modemctl <= wr_data;
                REG_SCRATCH:  cfg.scratch  <= wr_data;
                default: ;
            endcase
        end
    end

    assert_divisor_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == REG_LINECTL && wr_data[LCR_DIVACC])
        |=> (cfg.div_lo == 8'h00) && (cfg.div_hi == 8'h00));

    assert_ien_kept_in_divacc_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == REG_IEN && divacc) |=> $stable(cfg.ien));

endmodule

// File: rtl/lbu_status.sv
module lbu_status
    import lbu_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [3:0]    ien,
    input  logic [7:0]    modemctl,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] trig,
    input  logic          empty,
    input  logic          overrun,
    output logic [7:0]    ident,
    output logic [7:0]    linestat,
    output logic [7:0]    modemstat
);

    logic c_ls, c_rd, c_te, c_ms, full, cts;

    assign c_ls = ien[IEN_LINESTAT] && overrun;
    assign c_rd = ien[IEN_RXDATA]   && (count >= trig);
    assign c_te = ien[IEN_TXEMPTY]  && empty;
    assign c_ms = ien[IEN_MODEM]    && (modemctl[MCR_DTR] || modemctl[MCR_RTS]);

    assign ident = ident_code(c_ls, c_rd, c_te, c_ms);

    assign linestat = {1'b0, empty, empty, 3'b000, overrun, !empty};

    assign full      = (count >= limit);
    assign cts       = !(modemctl[MCR_AUTOFLOW] && full);
    assign modemstat = {1'b1, 1'b0, 1'b1, cts, 2'b00, 1'b1, cts};

endmodule

// File: rtl/lbu_regs_top.sv
module lbu_regs_top
    import lbu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq_pulse
);

    cfg_t          cfg;
    logic          push_req, clr_req, ien_txempty_wr, pop_req;
    logic [7:0]    head_data, ident, linestat, modemstat;
    logic [CW-1:0] count, count_nxt, limit, trig;
    logic          empty, push_ok, pop_ok, overrun, divacc;
    logic          ev_ovr, ev_trig, ev_drain, ev_arm;
    reg_addr_e     rsel;

    assign divacc  = cfg.linectl[LCR_DIVACC];
    assign rsel    = reg_addr_e'(rd_addr);
    assign pop_req = rd_en && (rsel == REG_DATA) && !divacc;
    assign limit   = cfg.fifo_on ? CW'(DEPTH) : CW'(1);
    assign trig    = CW'(trig_level(cfg.fifo_on, cfg.trig_sel));

    lbu_ctrl_regs u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .cfg            (cfg),
        .push_req       (push_req),
        .clr_req        (clr_req),
        .ien_txempty_wr (ien_txempty_wr)
    );

    lbu_loop_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_req),
        .pop       (pop_req),
        .clr       (clr_req),
        .limit     (limit),
        .din       (wr_data),
        .head_data (head_data),
        .count     (count),
        .count_nxt (count_nxt),
        .empty     (empty),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .overrun   (overrun)
    );

    lbu_status #(.CW(CW)) u_status (
        .ien       (cfg.ien),
        .modemctl  (cfg.modemctl),
        .count     (count),
        .limit     (limit),
        .trig      (trig),
        .empty     (empty),
        .overrun   (overrun),
        .ident     (ident),
        .linestat  (linestat),
        .modemstat (modemstat)
    );

    always_comb begin
        case (rsel)
            REG_DATA:      rd_data = divacc ? cfg.div_lo : head_data;
            REG_IEN:       rd_data = divacc ? cfg.div_hi : {4'h0, cfg.ien};
            REG_IDENT:     rd_data = ident;
            REG_LINECTL:   rd_data = cfg.linectl;
            REG_MODEMCTL:  rd_data = cfg.modemctl;
            REG_LINESTAT:  rd_data = linestat;
            REG_MODEMSTAT: rd_data = modemstat;
            default:       rd_data = cfg.scratch;
        endcase
    end

    assign ev_ovr   = push_req && !push_ok && cfg.ien[IEN_LINESTAT];
    assign ev_trig  = push_ok && cfg.ien[IEN_RXDATA] && (count_nxt == trig);
    assign ev_drain = pop_ok && cfg.ien[IEN_TXEMPTY] && (count_nxt == '0);
    assign ev_arm   = ien_txempty_wr && empty;

    always_ff @(posedge clk) begin
        if (rst) irq_pulse <= 1'b0;
        else     irq_pulse <= ev_ovr || ev_trig || ev_drain || ev_arm;
    end

    assert_pulse_cause_R12: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(wr_en || rd_en));

    assert_divacc_no_push_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0 && divacc && !rd_en) |=> $stable(count));

    assert_same_cycle_full_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && count == limit) |=> (count == $past(count)) && !overrun);

endmodule

// File: tb/lbu_regs_top_tb_top.sv
module lbu_regs_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_pulse;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    lbu_regs_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // Monitor: compares read data against the scoreboard queue.
    always begin
        @(negedge clk);
        #2;
        if (rd_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: read offset %0d got %02h expected %02h", t, rd_addr, rd_data, e);
            end
        end
    end

    task automatic check_irq(input bit ei, input string t);
        checks++;
        if (irq_pulse !== ei) begin
            errors++;
            $display("FAIL %s: irq_pulse got %0b expected %0b", t, irq_pulse, ei);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit ei, input string t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #2 check_irq(ei, t);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input bit ei, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        #2 check_irq(ei, t);
    endtask

    task automatic both(input logic [7:0] d, input logic [7:0] e, input bit ei, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = d;
        rd_en = 1'b1; rd_addr = 3'd0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #2 check_irq(ei, t);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2 check_irq(1'b0, "R1");

        // R1 reset values
        rd(3'd2, 8'hC1, 0, "R1");
        rd(3'd5, 8'h60, 0, "R1");
        rd(3'd6, 8'hB3, 0, "R1");
        rd(3'd1, 8'h00, 0, "R1");
        rd(3'd3, 8'h00, 0, "R1");
        rd(3'd4, 8'h00, 0, "R1");
        rd(3'd7, 8'h00, 0, "R1");
        wr(3'd7, 8'h5A, 0, "R12");
        rd(3'd7, 8'h5A, 0, "R12");

        // R2 loopback order
        wr(3'd0, 8'h11, 0, "R2");
        wr(3'd0, 8'h22, 0, "R2");
        wr(3'd0, 8'h33, 0, "R2");
        rd(3'd5, 8'h01, 0, "R2");
        rd(3'd0, 8'h11, 0, "R2");
        rd(3'd0, 8'h22, 0, "R2");
        rd(3'd0, 8'h33, 0, "R2");
        rd(3'd5, 8'h60, 0, "R2");

        // R4 empty read
        rd(3'd0, 8'h00, 0, "R4");
        rd(3'd5, 8'h60, 0, "R4");
        wr(3'd0, 8'h44, 0, "R4");
        rd(3'd0, 8'h44, 0, "R4");

        // R7 trigger level 4
        wr(3'd2, 8'h41, 0, "R6");
        wr(3'd1, 8'h01, 0, "R7");
        wr(3'd0, 8'h01, 0, "R7");
        wr(3'd0, 8'h02, 0, "R7");
        wr(3'd0, 8'h03, 0, "R7");
        wr(3'd0, 8'h04, 1, "R7");
        wr(3'd0, 8'h05, 0, "R7");
        rd(3'd2, 8'hC4, 0, "R8");
        wr(3'd2, 8'h43, 0, "R6");
        rd(3'd5, 8'h60, 0, "R6");
        rd(3'd2, 8'hC1, 0, "R8");

        // R10 empty events and IER nibble
        wr(3'd1, 8'h02, 1, "R10");
        rd(3'd2, 8'hC2, 0, "R8");
        rd(3'd1, 8'h02, 0, "R10");
        wr(3'd1, 8'hF3, 1, "R10");
        rd(3'd1, 8'h03, 0, "R10");
        wr(3'd0, 8'hAA, 0, "R7");
        rd(3'd2, 8'hC1, 0, "R8");
        rd(3'd0, 8'hAA, 1, "R10");

        // R3 overrun on full queue
        wr(3'd2, 8'h07, 0, "R6");
        wr(3'd1, 8'h04, 0, "R3");
        for (int i = 0; i < 16; i++) wr(3'd0, 8'h80 + 8'(i), 0, "R2");
        wr(3'd0, 8'hEE, 1, "R3");
        rd(3'd5, 8'h03, 0, "R3");
        rd(3'd2, 8'hC6, 0, "R8");
        rd(3'd6, 8'hB3, 0, "R9");
        wr(3'd4, 8'h20, 0, "R9");
        rd(3'd6, 8'hA2, 0, "R9");

        // R11 simultaneous write and read on a full queue
        both(8'h99, 8'h80, 0, "R11");
        rd(3'd5, 8'h01, 0, "R11");
        for (int i = 1; i < 16; i++) rd(3'd0, 8'h80 + 8'(i), 0, "R11");
        rd(3'd0, 8'h99, 0, "R11");
        rd(3'd5, 8'h60, 0, "R2");
        rd(3'd6, 8'hB3, 0, "R9");

        // R8 modem status and priority over it
        wr(3'd1, 8'h08, 0, "R8");
        wr(3'd4, 8'h23, 0, "R8");
        rd(3'd2, 8'hC0, 0, "R8");
        wr(3'd1, 8'h0A, 1, "R10");
        rd(3'd2, 8'hC2, 0, "R8");

        // R6 FIFO disabled: depth 1, trigger 1
        wr(3'd2, 8'h00, 0, "R6");
        wr(3'd1, 8'h05, 0, "R6");
        wr(3'd0, 8'h10, 1, "R6");
        wr(3'd0, 8'h20, 1, "R6");
        rd(3'd5, 8'h03, 0, "R6");
        rd(3'd2, 8'hC6, 0, "R8");
        rd(3'd0, 8'h10, 0, "R6");
        rd(3'd5, 8'h62, 0, "R3");
        rd(3'd6, 8'hB3, 0, "R9");

        // R5 divisor access
        wr(3'd3, 8'h83, 0, "R5");
        rd(3'd3, 8'h83, 0, "R5");
        rd(3'd0, 8'h00, 0, "R5");
        rd(3'd1, 8'h00, 0, "R5");
        wr(3'd0, 8'h34, 0, "R5");
        wr(3'd1, 8'h12, 0, "R5");
        rd(3'd0, 8'h34, 0, "R5");
        rd(3'd1, 8'h12, 0, "R5");
        rd(3'd5, 8'h62, 0, "R5");
        wr(3'd3, 8'h03, 0, "R5");
        rd(3'd1, 8'h05, 0, "R5");
        rd(3'd0, 8'h00, 0, "R5");
        wr(3'd3, 8'h83, 0, "R5");
        rd(3'd0, 8'h00, 0, "R5");
        rd(3'd1, 8'h00, 0, "R5");
        wr(3'd3, 8'h03, 0, "R12");

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule